// File: doc/BRIEF.md
# Asynchronous Request Source Filter

This block sits on the receive side of a serial-bus link controller. For every inbound asynchronous request it decides whether the request is accepted or silently dropped, based on the node that sent it. A dropped request gets no acknowledge. An accepted request is then steered to one of three places: the direct memory path, the software request queue, or the link's own registers. Responses are never filtered.

Software controls the filter through a 64-bit permission word, split into two 32-bit halves. Each half is written only through a pair of addresses, one that sets bits and one that clears them. The top bit of the permission word is a grant-everyone flag. The other 63 bits each permit one node on the local bus. A bus reset forgets every per-node grant but keeps the grant-everyone flag. Configuration ROM quadlet reads and isochronous resource register accesses skip the filter.

Each request is presented for one cycle with `req_valid`. The verdict appears on the `dec_*` outputs exactly one clock later.

Top module: `arq_src_filter`

## Requirements
- R1: A write to 100h sets the upper permission half, 104h clears it, 108h sets the lower half and 10Ch clears it. Only the 1 bits of the write data take effect; 0 bits leave the stored bit unchanged.
- R2: Upper half bit 31 is the grant-everyone flag. Upper bits 30:0 permit nodes 62..32, and lower bits 31:0 permit nodes 31..0.
- R3: Reading either the set address or the clear address of a half returns the current contents of that half on `rd_data` in the same cycle.
- R4: After power-on reset, both halves read 0 and `dec_valid` is 0.
- R5: A `bus_reset` pulse clears all 63 node bits and keeps the grant-everyone flag. When a set write and a bus reset fall in the same cycle, the node bits end up 0.
- R6: While the grant-everyone flag is 1, a request from any node on any bus passes the filter.
- R7: The sourceID is bus field [15:6] followed by node field [5:0]. A set node bit admits a request only when the bus field equals `local_bus` or 3FFh; any other bus field is ignored.
- R8: An ignored request gives `dec_accept`=0 and `dec_route`=0 (none), which means no acknowledge is sent.
- R9: Node 63 has no permission bit. With the grant-everyone flag at 0, a request from node 63 is always ignored.
- R10: A quadlet read whose offset lies in FFFF_F000_0400h..FFFF_F000_07FFh bypasses the filter while `link_en`=1, giving route 3 (local). With `link_en`=0 the read is filtered like any other request.
- R11: Any non-response request whose offset lies in FFFF_F000_021Ch..FFFF_F000_022Bh bypasses the filter and gets route 3 (local).
- R12: A response (`req_is_resp`=1) is always accepted with route 4 (response).
- R13: A request that passes the filter is steered as follows:
  - it goes to route 1 (physical) when `phys_ok`=1 and the offset is at most 0000_FFFF_FFFFh;
  - otherwise it goes to route 2 (request queue) when `arctx_en`=1;
  - otherwise it is ignored.
- R14: `dec_valid` is high exactly in the cycle after each `req_valid` cycle, including back-to-back requests. The verdict reflects the permission state held at that strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_reset | input | 1 | One-cycle bus reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| local_bus | input | 10 | Local bus number |
| link_en | input | 1 | Link enabled |
| arctx_en | input | 1 | Request queue context enabled |
| phys_ok | input | 1 | Physical path permits this request |
| req_valid | input | 1 | Request strobe |
| req_src | input | 16 | Request sourceID |
| req_offset | input | 48 | Request destination offset |
| req_is_resp | input | 1 | Packet is a response |
| req_qread | input | 1 | Packet is a quadlet read request |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Request accepted (acknowledge sent) |
| dec_route | output | 3 | 0 none, 1 physical, 2 request queue, 3 local, 4 response |

## Verification
The properties assume that request fields and the control inputs `local_bus`, `link_en`, `arctx_en` and `phys_ok` are sampled only on a `req_valid` cycle. The grant-everyone retention property assumes that no register write accompanies the bus reset in that cycle. The accept-all property assumes the request queue is enabled on the strobe cycle. The stimulus changes control inputs only between requests, on the falling edge. It issues its pure bus-reset pulses with `wr_en` low, and checks the combined reset-plus-write case through register reads rather than through the retention property.

// File: rtl/arqf_pkg.sv
package arqf_pkg;

   typedef enum logic [2:0] {
      RT_NONE  = 3'd0,
      RT_PHYS  = 3'd1,
      RT_ARREQ = 3'd2,
      RT_LOCAL = 3'd3,
      RT_RESP  = 3'd4
   } route_e;

   typedef struct packed {
      logic   accept;
      route_e route;
   } verdict_t;

endpackage

// File: rtl/arqf_perm_bank.sv
module arqf_perm_bank #(
   parameter int DATA_W   = 32,
   parameter int WORDS    = 2,
   parameter int ADDR_W   = 12,
   parameter int REG_BASE = 'h100,
   localparam int TOTAL   = DATA_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [TOTAL-1:0]  perm
);

   logic [DATA_W-1:0] word_q   [WORDS];
   logic [WORDS-1:0]  rd_sel;

   genvar w;
   generate
      for (w = 0; w < WORDS; w++) begin : g_word
         // address order: index 0 is the most significant half
         localparam int SLOT = WORDS - 1 - w;
         localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(REG_BASE + w * 8);
         localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(REG_BASE + w * 8 + 4);
         // only the grant-everyone bit survives a bus reset
         localparam logic [DATA_W-1:0] KEEP =
            (SLOT == WORDS - 1) ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

         logic              set_hit, clr_hit;
         logic [DATA_W-1:0] nxt;

         assign set_hit = wr_en && (wr_addr == SET_A);
         assign clr_hit = wr_en && (wr_addr == CLR_A);

         always_comb begin
            nxt = word_q[SLOT];
            if (set_hit) nxt = nxt | wr_data;
            if (clr_hit) nxt = nxt & ~wr_data;
            if (bus_reset) nxt = nxt & KEEP;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[SLOT] <= '0;
            else        word_q[SLOT] <= nxt;
         end

         assign rd_sel[SLOT] = (rd_addr == SET_A) || (rd_addr == CLR_A);
         assign perm[SLOT*DATA_W +: DATA_W] = word_q[SLOT];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (rd_sel[i]) rd_data = rd_data | word_q[i];
      end
   end

endmodule

// File: rtl/arqf_srcmatch.sv
module arqf_srcmatch #(
   parameter int BUS_W  = 10,
   parameter int NODE_W = 6,
   localparam int TOTAL = 2 ** NODE_W,
   localparam int SRC_W = BUS_W + NODE_W
) (
   input  logic [SRC_W-1:0] src,
   input  logic [BUS_W-1:0] local_bus,
   input  logic [TOTAL-1:0] perm,
   output logic             permitted
);

   localparam logic [NODE_W-1:0] FLAG_NODE = '1;
   localparam logic [BUS_W-1:0]  ALIAS_BUS = '1;

   logic [NODE_W-1:0] node;
   logic [BUS_W-1:0]  bus;
   logic              bus_ok, node_bit;

   assign node     = src[NODE_W-1:0];
   assign bus      = src[NODE_W +: BUS_W];
   assign bus_ok   = (bus == ALIAS_BUS) || (bus == local_bus);
   // the top slot holds the grant-everyone flag, not a node grant
   assign node_bit = (node != FLAG_NODE) && perm[node];

   assign permitted = perm[TOTAL-1] || (bus_ok && node_bit);

endmodule

// File: rtl/arqf_window.sv
module arqf_window #(
   parameter int OFS_W                  = 48,
   parameter logic [OFS_W-1:0] CFG_BASE = 48'hFFFF_F000_0400,
   parameter logic [OFS_W-1:0] CFG_SPAN = 48'h400,
   parameter logic [OFS_W-1:0] ISO_BASE = 48'hFFFF_F000_021C,
   parameter logic [OFS_W-1:0] ISO_SPAN = 48'h10,
   parameter bit ISO_BYPASS_EN          = 1'b1
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic             qread,
   input  logic             link_en,
   output logic             cfg_hit,
   output logic             iso_hit
);

   localparam logic [OFS_W:0] CFG_END = {1'b0, CFG_BASE} + {1'b0, CFG_SPAN};
   localparam logic [OFS_W:0] ISO_END = {1'b0, ISO_BASE} + {1'b0, ISO_SPAN};

   logic in_cfg;
   assign in_cfg  = (ofs >= CFG_BASE) && ({1'b0, ofs} < CFG_END);
   assign cfg_hit = qread && link_en && in_cfg;

   generate
      if (ISO_BYPASS_EN) begin : g_iso
         assign iso_hit = (ofs >= ISO_BASE) && ({1'b0, ofs} < ISO_END);
      end else begin : g_no_iso
         assign iso_hit = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/arqf_verdict.sv
module arqf_verdict
   import arqf_pkg::*;
#(
   parameter int OFS_W                  = 48,
   parameter logic [OFS_W-1:0] PHYS_TOP = 48'h0000_FFFF_FFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OFS_W-1:0] ofs,
   input  logic             is_resp,
   input  logic             bypass,
   input  logic             permitted,
   input  logic             phys_ok,
   input  logic             arctx_en,
   output logic             dec_valid,
   output verdict_t         dec
);

   verdict_t v_nxt;

   always_comb begin
      v_nxt = '{accept: 1'b0, route: RT_NONE};
      if (is_resp) begin
         v_nxt = '{accept: 1'b1, route: RT_RESP};
      end else if (bypass) begin
         v_nxt = '{accept: 1'b1, route: RT_LOCAL};
      end else if (permitted) begin
         if (phys_ok && (ofs <= PHYS_TOP))
            v_nxt = '{accept: 1'b1, route: RT_PHYS};
         else if (arctx_en)
            v_nxt = '{accept: 1'b1, route: RT_ARREQ};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec       <= '{accept: 1'b0, route: RT_NONE};
      end else begin
         dec_valid <= req_valid;
         if (req_valid) dec <= v_nxt;
         else           dec <= '{accept: 1'b0, route: RT_NONE};
      end
   end

endmodule

// File: rtl/arq_src_filter.sv
module arq_src_filter
   import arqf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int REG_BASE = 'h100,
   parameter int BUS_W    = 10,
   parameter int NODE_W   = 6,
   parameter int OFS_W    = 48,
   parameter bit ISO_BYPASS_EN = 1'b1,
   localparam int TOTAL   = 2 ** NODE_W,
   localparam int WORDS   = TOTAL / DATA_W,
   localparam int SRC_W   = BUS_W + NODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [BUS_W-1:0]  local_bus,
   input  logic              link_en,
   input  logic              arctx_en,
   input  logic              phys_ok,
   input  logic              req_valid,
   input  logic [SRC_W-1:0]  req_src,
   input  logic [OFS_W-1:0]  req_offset,
   input  logic              req_is_resp,
   input  logic              req_qread,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [2:0]        dec_route
);

   generate
      if (TOTAL % DATA_W != 0) begin : g_bad_split
         $error("permission width must be a multiple of the register width");
      end
      if (WORDS < 1) begin : g_bad_words
         $error("at least one permission register half is needed");
      end
      if (OFS_W < 33) begin : g_bad_ofs
         $error("offset must be wider than the physical window");
      end
   endgenerate

   logic [TOTAL-1:0] perm;
   logic             permitted, cfg_hit, iso_hit;
   verdict_t         dec;

   arqf_perm_bank #(
      .DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W), .REG_BASE(REG_BASE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .perm(perm)
   );

   arqf_srcmatch #(.BUS_W(BUS_W), .NODE_W(NODE_W)) u_match (
      .src(req_src), .local_bus(local_bus), .perm(perm),
      .permitted(permitted)
   );

   arqf_window #(.OFS_W(OFS_W), .ISO_BYPASS_EN(ISO_BYPASS_EN)) u_win (
      .ofs(req_offset), .qread(req_qread), .link_en(link_en),
      .cfg_hit(cfg_hit), .iso_hit(iso_hit)
   );

   arqf_verdict #(.OFS_W(OFS_W)) u_verdict (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .ofs(req_offset), .is_resp(req_is_resp),
      .bypass(cfg_hit || iso_hit), .permitted(permitted),
      .phys_ok(phys_ok), .arctx_en(arctx_en),
      .dec_valid(dec_valid), .dec(dec)
   );

   assign dec_accept = dec.accept;
   assign dec_route  = dec.route;

endmodule

// File: rtl/arqf_checker.sv
module arqf_checker #(
   parameter int TOTAL = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_reset,
   input logic             wr_en,
   input logic             req_valid,
   input logic             req_is_resp,
   input logic             arctx_en,
   input logic [TOTAL-1:0] perm,
   input logic             dec_valid,
   input logic             dec_accept,
   input logic [2:0]       dec_route
);

   a_r14_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);

   a_r14_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);

   a_r5_nodes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (perm[TOTAL-2:0] == '0));

   a_r5_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_reset && !wr_en) |=> (perm[TOTAL-1] == $past(perm[TOTAL-1])));

   a_r12_response_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_resp) |=> (dec_accept && dec_route == 3'd4));

   a_r8_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |-> (dec_route == 3'd0));

   a_r6_grant_everyone: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && perm[TOTAL-1] && arctx_en) |=> dec_accept);

endmodule

bind arq_src_filter arqf_checker #(.TOTAL(TOTAL)) u_arqf_checker (
   .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_en(wr_en),
   .req_valid(req_valid), .req_is_resp(req_is_resp), .arctx_en(arctx_en),
   .perm(perm), .dec_valid(dec_valid), .dec_accept(dec_accept),
   .dec_route(dec_route)
);

// File: tb/arq_src_filter_test.sv
module arq_src_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_reset = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [9:0]  local_bus = 10'h005;
   logic        link_en = 1'b1;
   logic        arctx_en = 1'b1;
   logic        phys_ok = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_src = '0;
   logic [47:0] req_offset = '0;
   logic        req_is_resp = 1'b0;
   logic        req_qread = 1'b0;
   logic        dec_valid, dec_accept;
   logic [2:0]  dec_route;

   always #2 clk = ~clk;

   arq_src_filter uut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .local_bus(local_bus), .link_en(link_en), .arctx_en(arctx_en),
      .phys_ok(phys_ok), .req_valid(req_valid), .req_src(req_src),
      .req_offset(req_offset), .req_is_resp(req_is_resp),
      .req_qread(req_qread), .dec_valid(dec_valid),
      .dec_accept(dec_accept), .dec_route(dec_route)
   );

   typedef struct {
      logic       acc;
      logic [2:0] rt;
      string      tag;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic [63:0] shadow = '0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected verdict computed from the requirements
   function automatic logic [3:0] model(logic [15:0] s, logic [47:0] o,
                                        logic resp, logic qr);
      logic [9:0] b = s[15:6];
      logic [5:0] n = s[5:0];
      logic pass;
      if (resp) return {1'b1, 3'd4};                                   // R12
      if (qr && link_en && o >= 48'hFFFF_F000_0400 && o <= 48'hFFFF_F000_07FF)
         return {1'b1, 3'd3};                                          // R10
      if (o >= 48'hFFFF_F000_021C && o <= 48'hFFFF_F000_022B)
         return {1'b1, 3'd3};                                          // R11
      pass = shadow[63] ||
             ((b == 10'h3FF || b == local_bus) && n != 6'd63 && shadow[n]);
      if (!pass) return {1'b0, 3'd0};                                  // R8
      if (phys_ok && o <= 48'h0000_FFFF_FFFF) return {1'b1, 3'd1};     // R13
      if (arctx_en) return {1'b1, 3'd2};
      return {1'b0, 3'd0};
   endfunction

   task automatic wr(logic [11:0] a, logic [31:0] d, logic br);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; bus_reset = br;
      case (a)
         12'h100: shadow[63:32] = shadow[63:32] | d;
         12'h104: shadow[63:32] = shadow[63:32] & ~d;
         12'h108: shadow[31:0]  = shadow[31:0] | d;
         12'h10C: shadow[31:0]  = shadow[31:0] & ~d;
         default: ;
      endcase
      if (br) shadow[62:0] = '0;
      @(negedge clk);
      wr_en = 1'b0; bus_reset = 1'b0;
   endtask

   task automatic pulse_bus_reset();
      @(negedge clk);
      bus_reset = 1'b1;
      shadow[62:0] = '0;
      @(negedge clk);
      bus_reset = 1'b0;
   endtask

   task automatic rd_check(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_addr = a;
      #1 check(tag, {32'h0, rd_data}, {32'h0, exp});
   endtask

   // driver: one request per call, valid left high until idle()
   task automatic send(logic [15:0] s, logic [47:0] o, logic resp, logic qr,
                       string tag);
      exp_t e;
      logic [3:0] m;
      @(negedge clk);
      req_valid = 1'b1; req_src = s; req_offset = o;
      req_is_resp = resp; req_qread = qr;
      m = model(s, o, resp, qr);
      e.acc = m[3]; e.rt = m[2:0]; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_is_resp = 1'b0; req_qread = 1'b0;
   endtask

   task automatic req(logic [15:0] s, logic [47:0] o, logic resp, logic qr,
                      string tag);
      send(s, o, resp, qr, tag);
      idle();
   endtask

   // monitor: pops expected verdicts as the design produces them
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (sb.size() == 0) begin
            check("R14 unexpected verdict", 64'(dec_valid), 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {60'h0, dec_accept, dec_route}, {60'h0, e.acc, e.rt});
         end
      end
   end

   initial begin
      repeat (1000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R14 actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk, n_bad);
         $finish;
      end
   end

   localparam logic [47:0] HI = 48'h1_0000_0000;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4 reset state
      rd_check(12'h100, 32'h0, "R4 upper after reset");
      rd_check(12'h108, 32'h0, "R4 lower after reset");
      check("R4 dec_valid after reset", 64'(dec_valid), 64'd0);

      // R1 R3 set/clear semantics, read through both addresses
      wr(12'h108, 32'h0000_0005, 1'b0);
      rd_check(12'h108, 32'h0000_0005, "R1 set lower");
      rd_check(12'h10C, 32'h0000_0005, "R3 read via clear address");
      wr(12'h10C, 32'h0000_0001, 1'b0);
      rd_check(12'h108, 32'h0000_0004, "R1 clear lower bit");
      wr(12'h108, 32'h0000_0000, 1'b0);
      rd_check(12'h108, 32'h0000_0004, "R1 zero data no effect");
      wr(12'h100, 32'h0000_0001, 1'b0);
      rd_check(12'h104, 32'h0000_0001, "R2 node 32 in upper bit 0");

      // R7 bus field matching, R13 routing to request queue
      req({10'h005, 6'd2}, HI, 1'b0, 1'b0, "R7 local bus node 2");
      req({10'h3FF, 6'd2}, HI, 1'b0, 1'b0, "R7 alias bus node 2");
      req({10'h007, 6'd2}, HI, 1'b0, 1'b0, "R7 foreign bus ignored");
      req({10'h005, 6'd0}, HI, 1'b0, 1'b0, "R8 cleared node ignored");
      req({10'h005, 6'd32}, HI, 1'b0, 1'b0, "R2 node 32 permitted");
      req({10'h005, 6'd63}, HI, 1'b0, 1'b0, "R9 node 63 without flag");

      // R13 routing choices
      phys_ok = 1'b1;
      req({10'h005, 6'd2}, 48'h0000_0000_1000, 1'b0, 1'b0, "R13 physical");
      req({10'h005, 6'd2}, 48'h0000_FFFF_FFFF, 1'b0, 1'b0, "R13 physical top");
      req({10'h005, 6'd2}, HI, 1'b0, 1'b0, "R13 above physical window");
      phys_ok = 1'b0;
      arctx_en = 1'b0;
      req({10'h005, 6'd2}, HI, 1'b0, 1'b0, "R13 queue disabled ignored");
      arctx_en = 1'b1;

      // R14 back-to-back strobes
      send({10'h005, 6'd2}, HI, 1'b0, 1'b0, "R14 back-to-back first");
      send({10'h005, 6'd3}, HI, 1'b0, 1'b0, "R14 back-to-back second");
      send({10'h3FF, 6'd32}, HI, 1'b0, 1'b0, "R14 back-to-back third");
      idle();

      // R6 grant-everyone flag, R9 node 63
      wr(12'h100, 32'h8000_0000, 1'b0);
      rd_check(12'h100, 32'h8000_0001, "R2 flag in upper bit 31");
      req({10'h005, 6'd63}, HI, 1'b0, 1'b0, "R9 node 63 with flag");
      req({10'h123, 6'd17}, HI, 1'b0, 1'b0, "R6 foreign bus with flag");

      // R5 bus reset
      wr(12'h108, 32'hFFFF_0000, 1'b0);
      pulse_bus_reset();
      rd_check(12'h100, 32'h8000_0000, "R5 flag kept, upper nodes cleared");
      rd_check(12'h108, 32'h0000_0000, "R5 lower nodes cleared");
      wr(12'h108, 32'h0000_00F0, 1'b1);
      rd_check(12'h108, 32'h0000_0000, "R5 bus reset beats set write");
      wr(12'h104, 32'h8000_0000, 1'b0);
      rd_check(12'h100, 32'h0000_0000, "R1 clear flag");
      req({10'h123, 6'd17}, HI, 1'b0, 1'b0, "R8 no grants ignored");

      // R12 responses, R10 R11 bypass windows
      req({10'h123, 6'd17}, HI, 1'b1, 1'b0, "R12 response passes");
      req({10'h123, 6'd9}, 48'hFFFF_F000_0404, 1'b0, 1'b1, "R10 config ROM read");
      req({10'h123, 6'd9}, 48'hFFFF_F000_07FF, 1'b0, 1'b1, "R10 config ROM end");
      req({10'h123, 6'd9}, 48'hFFFF_F000_0800, 1'b0, 1'b1, "R10 past config ROM");
      req({10'h123, 6'd9}, 48'hFFFF_F000_0404, 1'b0, 1'b0, "R10 not quadlet read");
      link_en = 1'b0;
      req({10'h123, 6'd9}, 48'hFFFF_F000_0404, 1'b0, 1'b1, "R10 link disabled");
      link_en = 1'b1;
      req({10'h123, 6'd9}, 48'hFFFF_F000_0220, 1'b0, 1'b0, "R11 isoch register");
      req({10'h123, 6'd9}, 48'hFFFF_F000_021C, 1'b0, 1'b0, "R11 isoch first");
      req({10'h123, 6'd9}, 48'hFFFF_F000_022C, 1'b0, 1'b0, "R11 past isoch");

      // R7 different local bus number
      local_bus = 10'h2A1;
      wr(12'h108, 32'h0000_0100, 1'b0);
      req({10'h2A1, 6'd8}, HI, 1'b0, 1'b0, "R7 new local bus");
      req({10'h005, 6'd8}, HI, 1'b0, 1'b0, "R7 old bus now foreign");

      repeat (3) @(negedge clk);
      check("R14 all verdicts seen", 64'(sb.size()), 64'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_bad);
      $finish;
   end

endmodule